// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives clause-22 style management frames on a two-wire serial management bus used to reach PHY registers. A host presents an operation (read or write), a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit data word, then pulses `start_i`. The block produces the management clock from the system clock through a programmable half-period divider. It shifts the frame out on the data line and controls the enable of the bidirectional data pin, which is split here into separate out, enable and in signals.

On a read the block releases the data line after the register number and collects the 16 bits the PHY returns. It then pulses `done_o` and presents the word on `rd_data_o`. On a write it drives the whole frame apart from a final released clock. Read frames last 64 management clocks and write frames last 65. Between frames the bus is parked with the clock low, the data output low and the enable off.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `mdc_o`, `mdio_o`, `mdio_oe_o`, `busy_o` and `done_o` are all low.
- R2: Management clocks 0 to 31 of every frame carry a 1 with the enable on (preamble).
- R3: Clocks 32 and 33 carry 0 then 1 (start field). Clocks 34 and 35 carry 1 then 0 when `op_wr_i`=0 (read) and 0 then 1 when `op_wr_i`=1 (write), all driven.
- R4: Clocks 36 to 40 carry `phy_addr_i` and clocks 41 to 45 carry `reg_addr_i`, each most significant bit first and driven.
- R5: A read frame has exactly 64 clocks. From clock 46 onward the enable is off and the data output is low. Clock 46 is the turnaround, clocks 47 to 62 return data and clock 63 is the final clock.
- R6: A write frame has exactly 65 clocks. Clocks 46 and 47 are driven low, clocks 48 to 63 carry `wr_data_i` most significant bit first and driven, and clock 64 has the enable off and the data output low.
- R7: `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low. `mdio_i` is sampled after `mdc_o` has risen, at the end of the high half.
- R8: Every low half and every high half of `mdc_o` lasts exactly `HALF_DIV` system clocks (default 4), so each bit takes 2*`HALF_DIV` cycles.
- R9: The returned read bits are assembled most significant first into `rd_data_o`. The value is valid when `done_o` pulses and holds unchanged until the next accepted start. A write frame leaves it untouched.
- R10: `done_o` is high for exactly one cycle, in the cycle after the final high half ends. In that cycle `busy_o` is already low and the bus is parked as in R1.
- R11: `start_i` is ignored while `busy_o` is high. The running frame keeps its type and length, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame (accepted only when idle) |
| op_wr_i | input | 1 | 1 = write, 0 = read |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register number |
| wr_data_i | input | 16 | Write data |
| mdio_i | input | 1 | Data line as seen at the pin |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rd_data_o | output | 16 | Captured read data |

## Verification
A fault in the bit counter or the frame shift register shows up at the pins within one management clock as a wrong preamble, field or enable value. It also shows up at the end of the frame as a 63, 65 or 66 clock total where 64 or 65 was due. A divider fault changes the length of a half period at the very next `mdc_o` edge. A fault in the capture window shifts or truncates the read word, and this is visible on `rd_data_o` when `done_o` pulses. A latched stray start appears as a second frame or as a changed frame type before the next idle gap.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = PRE_BITS + 4 + 2 * ADDR_W;   // driven head of every frame
  localparam int WR_BITS    = HDR_BITS + 2 + DATA_W + 1;   // 65
  localparam int RD_BITS    = HDR_BITS + 1 + DATA_W + 1;   // 64
  localparam int FRAME_BITS = WR_BITS;
  localparam int CAP_FIRST  = HDR_BITS + 1;
  localparam int CAP_LAST   = CAP_FIRST + DATA_W - 1;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic [FRAME_BITS-1:0] dout;
    logic [FRAME_BITS-1:0] den;
  } frame_t;

  // Frame image, bit FRAME_BITS-1 goes on the wire first.
  function automatic frame_t build_frame(input logic wr,
                                         input logic [ADDR_W-1:0] phy,
                                         input logic [ADDR_W-1:0] rg,
                                         input logic [DATA_W-1:0] wd);
    frame_t f;
    if (wr) begin
      f.dout = {{PRE_BITS{1'b1}}, 2'b01, 2'b01, phy, rg, 2'b00, wd, 1'b0};
      f.den  = {{(FRAME_BITS-1){1'b1}}, 1'b0};
    end else begin
      f.dout = {{PRE_BITS{1'b1}}, 2'b01, 2'b10, phy, rg, {(FRAME_BITS-HDR_BITS){1'b0}}};
      f.den  = {{HDR_BITS{1'b1}}, {(FRAME_BITS-HDR_BITS){1'b0}}};
    end
    return f;
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic bit_end_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          half_end;

  assign half_end  = en_i && (cnt_q == CNT_LAST);
  assign mdc_o     = phase_q;
  assign bit_end_o = half_end && phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (half_end) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R8: a phase flip only follows a full half period
  p_half_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && (phase_q != $past(phase_q))) |-> ($past(cnt_q) == CNT_LAST));

  // R1: clock parks low once disabled
  p_park_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !phase_q);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_wr_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bit_end_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] LAST_WR = CNT_W'(WR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_RD = CNT_W'(RD_BITS - 1);
  localparam logic [CNT_W-1:0] CAP_LO  = CNT_W'(CAP_FIRST);
  localparam logic [CNT_W-1:0] CAP_HI  = CNT_W'(CAP_LAST);
  localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_BITS);
  localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] N_WR    = CNT_W'(WR_BITS);
  localparam logic [CNT_W-1:0] N_RD    = CNT_W'(RD_BITS);

  logic              busy_q, done_q, wr_q;
  frame_t            frame_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rd_q;
  logic              accept, step, last_bit, in_cap;

  assign accept   = start_i && !busy_q;
  assign step     = busy_q && bit_end_i;
  assign last_bit = bit_cnt_q == (wr_q ? LAST_WR : LAST_RD);
  assign in_cap   = !wr_q && (bit_cnt_q >= CAP_LO) && (bit_cnt_q <= CAP_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      wr_q      <= 1'b0;
      frame_q   <= '0;
      bit_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        wr_q      <= op_wr_i;
        frame_q   <= build_frame(op_wr_i, phy_addr_i, reg_addr_i, wr_data_i);
        bit_cnt_q <= '0;
      end else if (step) begin
        frame_q.dout <= frame_q.dout << 1;
        frame_q.den  <= frame_q.den << 1;
        bit_cnt_q    <= bit_cnt_q + 1'b1;
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rd_q <= '0;
    else if (step && in_cap)  rd_q <= {rd_q[DATA_W-2:0], mdio_i};
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign mdio_o    = busy_q && frame_q.dout[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && frame_q.den[FRAME_BITS-1];
  assign rd_data_o = rd_q;

  p_preamble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (bit_cnt_q < PRE_END)) |-> (mdio_o && mdio_oe_o));

  p_read_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !wr_q && (bit_cnt_q >= HDR_END)) |-> !mdio_oe_o);

  p_frame_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (bit_cnt_q == (wr_q ? N_WR : N_RD)));

  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !$past(busy_q)) |-> $stable(rd_q));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(wr_q));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_wr_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mdio_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic bit_end;

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_clk_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (busy_o),
    .mdc_o     (mdc_o),
    .bit_end_o (bit_end)
  );

  mdio_frame_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_wr_i    (op_wr_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wr_data_i  (wr_data_i),
    .bit_end_i  (bit_end),
    .mdio_i     (mdio_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rd_data_o  (rd_data_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_o && !mdio_oe_o));

  p_change_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) &&
     ((mdio_o != $past(mdio_o)) || (mdio_oe_o != $past(mdio_oe_o)))) |-> !mdc_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int H = 4;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;  // write data, or PHY reply on reads
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h01, 5'h02, 16'hA5C3},
    '{1'b1, 5'h1F, 5'h00, 16'h8001},
    '{1'b0, 5'h10, 5'h1F, 16'hFFFF},
    '{1'b1, 5'h0A, 5'h15, 16'h3C5A},
    '{1'b0, 5'h00, 5'h11, 16'h0001}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, op_wr_i = 1'b0, mdio_i = 1'b1;
  logic [4:0]  phy_addr_i = '0, reg_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        mdc_o, mdio_o, mdio_oe_o, busy_o, done_o;
  logic [15:0] rd_data_o;

  always #2 clk_i = ~clk_i;

  mdio_master #(.HALF_DIV(H)) u_dut (.*);

  int checks = 0, failures = 0;
  int cyc = 0, rise_n = 0, last_rise = 0, per_err = 0, chg_err = 0, done_cnt = 0;
  logic prev_mdc = 0, prev_out = 0, prev_oe = 0;
  logic rec_out [0:69];
  logic rec_oe  [0:69];
  logic        resp_wr = 0;
  logic [15:0] resp_pat = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus monitor and PHY responder, away from the active edge
  always @(negedge clk_i) begin
    cyc++;
    if (done_o) done_cnt++;
    if (mdc_o && prev_mdc && (mdio_o != prev_out || mdio_oe_o != prev_oe)) chg_err++;
    if (mdc_o && !prev_mdc) begin
      if (rise_n > 0 && (cyc - last_rise) != 2 * H) per_err++;
      if (rise_n < 70) begin
        rec_out[rise_n] = mdio_o;
        rec_oe[rise_n]  = mdio_oe_o;
      end
      if (!resp_wr && rise_n >= 47 && rise_n <= 62) mdio_i = resp_pat[62 - rise_n];
      else mdio_i = 1'b1;
      last_rise = cyc;
      rise_n++;
    end
    if (!mdc_o && prev_mdc && (cyc - last_rise) != H) per_err++;
    prev_mdc = mdc_o;
    prev_out = mdio_o;
    prev_oe  = mdio_oe_o;
  end

  function automatic void exp_bit(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                                  input logic [15:0] wd, input int n,
                                  output logic o, output logic e);
    e = 1'b1;
    if (n < 32)       o = 1'b1;
    else if (n == 32) o = 1'b0;
    else if (n == 33) o = 1'b1;
    else if (n == 34) o = !wr;
    else if (n == 35) o = wr;
    else if (n < 41)  o = pa[40 - n];
    else if (n < 46)  o = ra[45 - n];
    else if (!wr) begin o = 1'b0; e = 1'b0; end
    else if (n < 48)  o = 1'b0;
    else if (n < 64)  o = wd[63 - n];
    else begin o = 1'b0; e = 1'b0; end
  endfunction

  task automatic launch(input vec_t v);
    @(negedge clk_i);
    rise_n = 0; per_err = 0; chg_err = 0; done_cnt = 0;
    resp_wr = v.wr; resp_pat = v.data;
    op_wr_i = v.wr; phy_addr_i = v.phy; reg_addr_i = v.rg; wr_data_i = v.data;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_frame(input vec_t v);
    int e_pre, e_hdr, e_addr, e_tail;
    logic o, e;
    while (!done_o) @(negedge clk_i);
    chk(!busy_o && !mdc_o && !mdio_o && !mdio_oe_o, "R10", "bus parked at done",
        {busy_o, mdc_o, mdio_o, mdio_oe_o}, 0);
    chk(rise_n == (v.wr ? 65 : 64), v.wr ? "R6" : "R5", "clock count", rise_n, v.wr ? 65 : 64);
    e_pre = 0; e_hdr = 0; e_addr = 0; e_tail = 0;
    for (int n = 0; n < 65 && n < rise_n; n++) begin
      exp_bit(v.wr, v.phy, v.rg, v.data, n, o, e);
      if (rec_out[n] !== o || rec_oe[n] !== e) begin
        if (n < 32) e_pre++; else if (n < 36) e_hdr++; else if (n < 46) e_addr++; else e_tail++;
      end
    end
    chk(e_pre == 0, "R2", "preamble bit errors", e_pre, 0);
    chk(e_hdr == 0, "R3", "start/opcode bit errors", e_hdr, 0);
    chk(e_addr == 0, "R4", "address bit errors", e_addr, 0);
    chk(e_tail == 0, v.wr ? "R6" : "R5", "tail bit errors", e_tail, 0);
    chk(per_err == 0, "R8", "half period errors", per_err, 0);
    chk(chg_err == 0, "R7", "changes while clock high", chg_err, 0);
    if (!v.wr) chk(rd_data_o == v.data, "R9", "read data", rd_data_o, v.data);
    @(negedge clk_i);
    chk(done_cnt == 1 && !done_o, "R10", "done pulse width", done_cnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] held;
    vec_t wv;
    repeat (3) @(negedge clk_i);
    chk(!mdc_o && !mdio_o && !mdio_oe_o && !busy_o && !done_o, "R1", "reset state",
        {mdc_o, mdio_o, mdio_oe_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!mdc_o && !mdio_oe_o && !busy_o, "R1", "idle after reset", {mdc_o, mdio_oe_o, busy_o}, 0);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      finish_frame(VECS[i]);
    end

    // R9: read value holds through idle activity and a write frame
    held = rd_data_o;
    mdio_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(rd_data_o == held, "R9", "hold while idle", rd_data_o, held);
    wv = '{1'b1, 5'h03, 5'h04, 16'h1234};
    launch(wv);
    finish_frame(wv);
    chk(rd_data_o == held, "R9", "hold across write", rd_data_o, held);

    // R11: start pulses during a write frame are ignored
    wv = '{1'b1, 5'h15, 5'h0A, 16'hC0DE};
    launch(wv);
    repeat (100) @(negedge clk_i);
    op_wr_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (200) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    op_wr_i = 1'b1;
    finish_frame(wv);
    repeat (30) @(negedge clk_i);
    chk(!busy_o && rise_n == 65, "R11", "no extra frame after busy starts", rise_n, 65);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule